// File: doc/BRIEF.md
# Power-Good Window Monitor

This block watches a digitized output-sense code and decides whether the supply is in regulation. It compares the sense code against a window placed relative to a target code and drives an active-high power-good flag. Separately, it raises a latched overvoltage fault when the sense code stays above the upper bound for a short qualification time. All timing is counted in ticks of a one-microsecond strobe, so the block runs from any system clock.

In normal operation the target is the reference code, which may be the internal reference or an externally driven margining value. When the reference code sits below a small threshold that means "grounded", the block switches to tracking operation. The tracking-input code then becomes the target for the whole window and for the overvoltage bound. A hysteretic tracker comparator on that same code must be high, and must stay high for the full rising qualification time, before power-good may assert. Window factors are applied with fixed-point multiplies by constants out of 256, so no divider is built.

Top module: `pgood_window_monitor`

## Requirements
- R1: Threshold codes are floor(target*k/256), with k = 307 for the upper bound (about 1.2x), 243 for the rising lower bound (about 0.95x) and 230 for the falling lower bound (about 0.90x). Power-good can only assert while the sense code is strictly above the rising lower bound and not above the upper bound.
- R2: Once power-good is high, a sense code between the falling and rising lower bounds keeps it high. Once it is low, a code in that band does not raise it.
- R3: Power-good rises on the clock edge after RISE_TICKS consecutive ticks with the rise condition true (enabled, in the rising window, no latched fault).
- R4: Power-good falls on the clock edge after FALL_TICKS consecutive ticks with the sense code below the falling lower bound.
- R5: A sense code above the upper bound for OV_TICKS consecutive ticks sets the overvoltage fault and clears power-good on the next edge. A shorter excursion sets nothing.
- R6: The overvoltage fault stays set until ov_clr is high or en rises, and clear wins over set in the same cycle. While the fault is set, power-good is low, and after a clear it needs a full RISE_TICKS qualification again.
- R7: With en low, power-good goes low on the next edge and stays low, while overvoltage detection keeps running.
- R8: When ref_code < REF_LOW_CODE, trk_code replaces ref_code as the target for every threshold, the overvoltage bound included.
- R9: In tracking operation, the tracker state sets when trk_code > TRK_HI_CODE and clears when trk_code < TRK_LO_CODE, and holds in between. Power-good is held low while it is clear, and asserts only after it has been set for RISE_TICKS ticks.
- R10: A qualification counter restarts from zero whenever its condition drops for a cycle, and advances only on cycles with us_tick high.
- R11: After reset, pgood and ov_fault are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable; its rising edge also clears the fault |
| ov_clr | input | 1 | Clears the latched overvoltage fault |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| sense_code | input | CODE_W | Digitized output-sense voltage |
| ref_code | input | CODE_W | Digitized reference voltage |
| trk_code | input | CODE_W | Digitized tracking-input voltage |
| pgood | output | 1 | Power-good, active high |
| ov_fault | output | 1 | Latched overvoltage fault |

## Verification
The properties assume that en and ov_clr change only between clock edges and that the input codes are already synchronous samples. The bench changes every input on the falling edge, and the block registers them on the rising edge. The properties also take us_tick to be a single-cycle strobe. The bench drives it every cycle for most scenarios and one cycle in four for the tick-rate scenario. The overvoltage and tracker properties rely on the codes holding steady between changes, which the stimulus does by stepping each code once and then holding it.

// File: rtl/pgmon_pkg.sv
package pgmon_pkg;
  localparam int unsigned FRAC_SH = 8;
  localparam logic [8:0]  K_OVER  = 9'd307;  // ~1.20x
  localparam logic [8:0]  K_RISE  = 9'd243;  // ~0.95x
  localparam logic [8:0]  K_FALL  = 9'd230;  // ~0.90x

  localparam int unsigned N_TMR  = 4;
  localparam int unsigned T_RISE = 0;
  localparam int unsigned T_FALL = 1;
  localparam int unsigned T_OV   = 2;
  localparam int unsigned T_TRK  = 3;

  // floor(x * k / 256)
  function automatic logic [31:0] frac_mul(input logic [31:0] x, input logic [8:0] k);
    logic [40:0] p;
    p = {9'd0, x} * {32'd0, k};
    return p[FRAC_SH +: 32];
  endfunction
endpackage

// File: rtl/pgmon_window_calc.sv
module pgmon_window_calc #(
  parameter int unsigned CODE_W       = 12,
  parameter int unsigned REF_LOW_CODE = 100,
  localparam int unsigned THR_W       = CODE_W + 1
) (
  input  logic [CODE_W-1:0] ref_code,
  input  logic [CODE_W-1:0] trk_code,
  output logic              track_mode,
  output logic [THR_W-1:0]  hi_thr,
  output logic [THR_W-1:0]  lo_rise,
  output logic [THR_W-1:0]  lo_fall
);
  import pgmon_pkg::*;

  logic [CODE_W-1:0] target;

  assign track_mode = ref_code < CODE_W'(REF_LOW_CODE);
  assign target     = track_mode ? trk_code : ref_code;

  assign hi_thr  = THR_W'(frac_mul(32'(target), K_OVER));
  assign lo_rise = THR_W'(frac_mul(32'(target), K_RISE));
  assign lo_fall = THR_W'(frac_mul(32'(target), K_FALL));
endmodule

// File: rtl/pgmon_qual_timer.sv
module pgmon_qual_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic tick,
  output logic done
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign done = (cnt == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!cond)         cnt <= '0;
    else if (tick && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pgmon_hyst_cmp.sv
module pgmon_hyst_cmp #(
  parameter int unsigned W       = 12,
  parameter int unsigned SET_LVL = 400,
  parameter int unsigned CLR_LVL = 300
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic         state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    state <= 1'b0;
    else if (level > W'(SET_LVL))  state <= 1'b1;
    else if (level < W'(CLR_LVL))  state <= 1'b0;
  end
endmodule

// File: rtl/pgood_window_monitor.sv
module pgood_window_monitor #(
  parameter int unsigned CODE_W       = 12,
  parameter int unsigned REF_LOW_CODE = 100,
  parameter int unsigned TRK_HI_CODE  = 400,
  parameter int unsigned TRK_LO_CODE  = 300,
  parameter int unsigned RISE_TICKS   = 1280,
  parameter int unsigned FALL_TICKS   = 150,
  parameter int unsigned OV_TICKS     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ov_clr,
  input  logic              us_tick,
  input  logic [CODE_W-1:0] sense_code,
  input  logic [CODE_W-1:0] ref_code,
  input  logic [CODE_W-1:0] trk_code,
  output logic              pgood,
  output logic              ov_fault
);
  import pgmon_pkg::*;

  localparam int unsigned THR_W = CODE_W + 1;
  localparam int unsigned TLIM [N_TMR] = '{RISE_TICKS, FALL_TICKS, OV_TICKS, RISE_TICKS};

  logic [THR_W-1:0] hi_thr, lo_rise, lo_fall, sense_x;
  logic             track_mode, trk_ok;
  logic             over_w, in_rise, below_fall;
  logic             en_q, en_rise;
  logic [N_TMR-1:0] t_cond, t_done;
  logic             rise_done, fall_done, ov_done, trk_done;
  logic             hold_gate, assert_gate, pg_next;

  pgmon_window_calc #(.CODE_W(CODE_W), .REF_LOW_CODE(REF_LOW_CODE)) u_calc (
    .ref_code(ref_code), .trk_code(trk_code), .track_mode(track_mode),
    .hi_thr(hi_thr), .lo_rise(lo_rise), .lo_fall(lo_fall)
  );

  pgmon_hyst_cmp #(.W(CODE_W), .SET_LVL(TRK_HI_CODE), .CLR_LVL(TRK_LO_CODE)) u_trk (
    .clk(clk), .rst_n(rst_n), .level(trk_code), .state(trk_ok)
  );

  assign sense_x    = {1'b0, sense_code};
  assign over_w     = sense_x > hi_thr;
  assign in_rise    = (sense_x > lo_rise) && !over_w;
  assign below_fall = sense_x < lo_fall;
  assign en_rise    = en && !en_q;

  assign t_cond[T_RISE] = en && in_rise && !ov_fault;
  assign t_cond[T_FALL] = below_fall;
  assign t_cond[T_OV]   = over_w;
  assign t_cond[T_TRK]  = track_mode && trk_ok;

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    pgmon_qual_timer #(.LIMIT(TLIM[i])) u_tmr (
      .clk(clk), .rst_n(rst_n), .cond(t_cond[i]), .tick(us_tick), .done(t_done[i])
    );
  end

  assign rise_done = t_done[T_RISE];
  assign fall_done = t_done[T_FALL];
  assign ov_done   = t_done[T_OV];
  assign trk_done  = t_done[T_TRK];

  assign hold_gate   = !track_mode || trk_ok;
  assign assert_gate = !track_mode || (trk_ok && trk_done);

  always_comb begin
    pg_next = pgood;
    if (!en || ov_done || ov_fault || !hold_gate) pg_next = 1'b0;
    else if (pgood && fall_done)                 pg_next = 1'b0;
    else if (!pgood && rise_done && assert_gate) pg_next = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pgood    <= 1'b0;
      ov_fault <= 1'b0;
    end else begin
      en_q  <= en;
      pgood <= pg_next;
      if (ov_clr || en_rise) ov_fault <= 1'b0;
      else if (ov_done)      ov_fault <= 1'b1;
    end
  end
endmodule

// File: rtl/pgmon_checker.sv
module pgmon_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic ov_clr,
  input logic pgood,
  input logic ov_fault,
  input logic en_rise,
  input logic rise_done,
  input logic fall_done,
  input logic ov_done,
  input logic track_mode,
  input logic trk_ok
);
  assert_pg_off_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pgood);

  assert_fault_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_fault && !ov_clr && !en_rise |=> ov_fault);

  assert_fault_forces_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_fault |-> !pgood);

  assert_ov_sets_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ov_done && !ov_clr && !en_rise |=> ov_fault);

  assert_rise_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> $past(rise_done));

  assert_fall_after_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pgood && fall_done |=> !pgood);

  assert_tracker_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    track_mode && !trk_ok |=> !pgood);
endmodule

bind pgood_window_monitor pgmon_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ov_clr(ov_clr), .pgood(pgood),
  .ov_fault(ov_fault), .en_rise(en_rise), .rise_done(rise_done),
  .fall_done(fall_done), .ov_done(ov_done), .track_mode(track_mode),
  .trk_ok(trk_ok)
);

// File: tb/pgood_window_monitor_test.sv
`timescale 1ns/1ps
module pgood_window_monitor_test;
  localparam int RISE = 20;
  localparam int FALL = 6;
  localparam int OVT  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ov_clr = 1'b0, us_tick = 1'b1;
  logic [11:0] sense_code = 12'd600, ref_code = 12'd600, trk_code = 12'd0;
  logic pgood, ov_fault;

  int compared = 0, mismatched = 0;
  bit slow_tick = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic  pg;
    logic  ov;
    string req;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  pgood_window_monitor #(
    .CODE_W(12), .REF_LOW_CODE(100), .TRK_HI_CODE(400), .TRK_LO_CODE(300),
    .RISE_TICKS(RISE), .FALL_TICKS(FALL), .OV_TICKS(OVT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .ov_clr(ov_clr), .us_tick(us_tick),
    .sense_code(sense_code), .ref_code(ref_code), .trk_code(trk_code),
    .pgood(pgood), .ov_fault(ov_fault)
  );

  // tick generator: every cycle, or one in four when slow_tick is set
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      us_tick = slow_tick ? (cyc % 4 == 0) : 1'b1;
    end
  end

  // monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        compared++;
        if (pgood !== e.pg || ov_fault !== e.ov) begin
          mismatched++;
          $display("FAIL %s: pgood=%0b ov_fault=%0b, expected pgood=%0b ov_fault=%0b",
                   e.req, pgood, ov_fault, e.pg, e.ov);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input logic pg, input logic ov, input string req);
    exp_t e;
    e.pg = pg; e.ov = ov; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic finish_run();
    step(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual hung, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_now(1'b0, 1'b0, "R11 reset state");

    // R7: disabled, in-window sense never raises pgood
    step(30);
    expect_now(1'b0, 1'b0, "R7 disabled holds pgood low");

    // R3 / R1: rising qualification (ref 600: hi 719, rise 569, fall 539)
    en = 1'b1;
    step(RISE);
    expect_now(1'b0, 1'b0, "R3 not before rise delay");
    step(1);
    expect_now(1'b1, 1'b0, "R3 rises after rise delay");

    // R2: band between fall and rise bounds keeps pgood
    sense_code = 12'd550;
    step(30);
    expect_now(1'b1, 1'b0, "R2 hysteresis band holds high");

    // R4: fall delay
    sense_code = 12'd530;
    step(FALL);
    expect_now(1'b1, 1'b0, "R4 not before fall delay");
    step(1);
    expect_now(1'b0, 1'b0, "R4 falls after fall delay");

    // R2 / R1: band does not raise a low pgood
    sense_code = 12'd550;
    step(30);
    expect_now(1'b0, 1'b0, "R2 band does not assert");

    // R10: fall counter restarts after a one-cycle recovery
    sense_code = 12'd600;
    step(RISE + 1);
    expect_now(1'b1, 1'b0, "R1 requalified in window");
    sense_code = 12'd530;
    step(4);
    sense_code = 12'd600;
    step(1);
    sense_code = 12'd530;
    step(FALL);
    expect_now(1'b1, 1'b0, "R10 fall counter restarted");
    step(1);
    expect_now(1'b0, 1'b0, "R10 fall after full delay");

    // R5: overvoltage qualification and latch
    sense_code = 12'd600;
    step(RISE + 1);
    expect_now(1'b1, 1'b0, "R1 high before overvoltage");
    sense_code = 12'd720;
    step(OVT);
    expect_now(1'b1, 1'b0, "R5 not before ov delay");
    step(1);
    expect_now(1'b0, 1'b1, "R5 ov fault set and pgood dropped");
    sense_code = 12'd600;
    step(30);
    expect_now(1'b0, 1'b1, "R6 fault latched and pgood held low");

    // R6: explicit clear then full requalification
    ov_clr = 1'b1;
    step(1);
    ov_clr = 1'b0;
    expect_now(1'b0, 1'b0, "R6 clear input drops fault");
    step(RISE);
    expect_now(1'b0, 1'b0, "R6 requalification not early");
    step(1);
    expect_now(1'b1, 1'b0, "R6 requalified after clear");

    // R7: overvoltage detected while disabled; R6: enable edge clears it
    en = 1'b0;
    sense_code = 12'd720;
    step(OVT);
    expect_now(1'b0, 1'b0, "R7 disabled pgood low, ov pending");
    step(1);
    expect_now(1'b0, 1'b1, "R7 ov detection active while disabled");
    sense_code = 12'd600;
    en = 1'b1;
    step(1);
    expect_now(1'b0, 1'b0, "R6 enable rising edge clears fault");
    step(30);
    expect_now(1'b1, 1'b0, "R3 high after re-enable");

    // R5: short excursion ignored
    sense_code = 12'd720;
    step(OVT - 1);
    sense_code = 12'd600;
    step(5);
    expect_now(1'b1, 1'b0, "R5 short excursion ignored");

    // R8 / R9: tracking operation
    en = 1'b0;
    step(2);
    ref_code = 12'd50;
    trk_code = 12'd200;
    sense_code = 12'd200;
    en = 1'b1;
    step(40);
    expect_now(1'b0, 1'b0, "R9 tracker low blocks pgood");
    trk_code = 12'd350;
    sense_code = 12'd350;
    step(40);
    expect_now(1'b0, 1'b0, "R9 tracker band does not set");
    trk_code = 12'd450;
    sense_code = 12'd450;
    step(RISE + 1);
    expect_now(1'b0, 1'b0, "R9 tracker delay not early");
    step(1);
    expect_now(1'b1, 1'b0, "R9 asserts after tracker delay");
    trk_code = 12'd350;
    sense_code = 12'd350;
    step(20);
    expect_now(1'b1, 1'b0, "R9 tracker band holds set");
    trk_code = 12'd250;
    sense_code = 12'd250;
    step(1);
    expect_now(1'b1, 1'b0, "R9 one edge before tracker drop");
    step(1);
    expect_now(1'b0, 1'b0, "R9 tracker clear drops pgood");
    trk_code = 12'd350;
    sense_code = 12'd350;
    step(40);
    expect_now(1'b0, 1'b0, "R9 tracker stays clear in band");

    // R8: overvoltage bound follows tracking target (450 -> 539)
    trk_code = 12'd450;
    sense_code = 12'd450;
    step(40);
    expect_now(1'b1, 1'b0, "R8 tracking target in window");
    sense_code = 12'd539;
    step(10);
    expect_now(1'b1, 1'b0, "R8 at upper bound not over");
    sense_code = 12'd540;
    step(OVT);
    expect_now(1'b1, 1'b0, "R8 over tracking bound pending");
    step(1);
    expect_now(1'b0, 1'b1, "R8 over tracking bound trips");

    // R10: counters advance on ticks only
    ref_code = 12'd600;
    sense_code = 12'd600;
    ov_clr = 1'b1;
    step(1);
    ov_clr = 1'b0;
    step(30);
    expect_now(1'b1, 1'b0, "R10 normal mode restored");
    slow_tick = 1'b1;
    step(1);
    sense_code = 12'd530;
    step(12);
    expect_now(1'b1, 1'b0, "R10 slow ticks delay the fall");
    step(28);
    expect_now(1'b0, 1'b0, "R10 fall after enough ticks");

    finished = 1'b1;
    finish_run();
  end
endmodule